// File: doc/BRIEF.md
# Interlaced Composite Sync Synthesizer

This block produces one composite sync wire for an interlaced video raster when the pixel source cannot emit a real vertical sync. It watches only the horizontal sync and a vertical helper signal. The helper is asserted once per field, and its length alternates between one line and two lines. The block counts horizontal sync leading edges while the helper is asserted. A one-line pulse means the next field is the long field. A two-line pulse means the next field is the short field.

Outside the vertical interval the output repeats horizontal sync two clocks late. When the block is locked, the first horizontal leading edge inside a helper pulse opens a window of broad pulses. The window spans a fixed number of half-lines. In each half-line, sync is held active for the measured half-line length minus the measured sync width. In the short field the broad pulses start half a line later than in the long field, and ordinary horizontal sync fills the half-line before them. Line length and sync width are measured continuously from the horizontal sync itself. The colour path is not touched.

Top module: `csync_synth`

## Requirements
- R1: While rst_ni is low, csync_o sits at the inactive sync level, which is high when SYNC_ACTIVE_LOW=1.
- R2: When no broad window is open, csync_o equals hsync_i delayed by exactly two clock cycles.
- R3: The half-line length is half the clock count between two consecutive hsync leading edges, rounded down. The sync width is the clock count from a leading edge to the following trailing edge. Both come from the last complete measurement before the window opens.
- R4: A helper pulse is valid only if exactly one or exactly two hsync leading edges fall inside it. A pulse with no leading edge, or with three or more, is malformed.
- R5: The block locks at the end of a valid helper pulse only if three conditions hold: a line period has been measured, the previous helper pulse was also valid, and the two pulses differ in length. Broad pulses are produced only while locked.
- R6: Inside the broad part of the window, at every half-line boundary, sync goes active for (half-line length minus sync width) cycles and is inactive for the rest of that half-line.
- R7: The broad part of the window lasts VS_HALF half-lines and then returns to plain passthrough.
- R8: After a one-line helper pulse, broad pulses start at the first leading edge inside the next helper pulse. After a two-line helper pulse, they start half a line after that edge, and csync_o follows hsync for the half-line in between.
- R9: A malformed helper pulse clears the lock. Broad pulses come back only after two more valid pulses of different lengths.
- R10: With SYNC_ACTIVE_LOW=1, hsync_i and csync_o are active-low. HELP_ACTIVE_LOW selects the active level of vhelp_i (default active-high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| hsync_i | input | 1 | horizontal sync from the pixel source |
| vhelp_i | input | 1 | vertical helper pulse, one or two lines long |
| csync_o | output | 1 | composite sync |

## Verification
The assertions assume that hsync_i and vhelp_i are synchronous to clk_i, and that the line period is at least four clocks so that a half-line is two clocks or more. They also assume the sync width is shorter than a half-line and that a broad window ends before the next helper pulse begins. The stimulus uses 64-clock lines with a 5-clock sync. It raises the helper partway through a line and drops it partway through a later line, so the helper never changes on the same cycle as a sync edge. Helper pulses are spaced seven idle lines apart. The sequence includes valid alternations, a three-line pulse and a pulse that contains no leading edge.

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_TWO  = 2'd2
  } pulse_cls_e;

  function automatic pulse_cls_e classify(input logic [1:0] edges);
    case (edges)
      2'd1:    return CLS_ONE;
      2'd2:    return CLS_TWO;
      default: return CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/csync_in_stage.sv
module csync_in_stage #(
  parameter bit SYNC_ACTIVE_LOW = 1'b1,
  parameter bit HELP_ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vhelp_i,
  output logic hs_o,
  output logic hs_rise_o,
  output logic hs_fall_o,
  output logic hv_o,
  output logic hv_fall_o
);

  logic hs_q, hs_p, hv_q, hv_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      hs_p <= 1'b0;
      hv_q <= 1'b0;
      hv_p <= 1'b0;
    end else begin
      hs_q <= hsync_i ^ SYNC_ACTIVE_LOW;
      hs_p <= hs_q;
      hv_q <= vhelp_i ^ HELP_ACTIVE_LOW;
      hv_p <= hv_q;
    end
  end

  assign hs_o      = hs_q;
  assign hs_rise_o = hs_q & ~hs_p;
  assign hs_fall_o = ~hs_q & hs_p;
  assign hv_o      = hv_q;
  assign hv_fall_o = ~hv_q & hv_p;

endmodule

// File: rtl/csync_meter.sv
module csync_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] wid_o,
  output logic             vld_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, len_q, wid_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             seen_q, vld_q;

  // saturating count of clocks since the last leading edge
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= '0;
      wid_q  <= '0;
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q <= rise_i ? '0 : cnt_inc;
      if (rise_i) begin
        seen_q <= 1'b1;
        if (seen_q) begin
          len_q <= cnt_inc;
          vld_q <= 1'b1;
        end
      end
      if (fall_i && seen_q) wid_q <= cnt_inc;
    end
  end

  assign half_o = {1'b0, len_q[CNT_W-1:1]};
  assign wid_o  = wid_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/csync_field.sv
module csync_field
  import csync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic hv_i,
  input  logic hv_fall_i,
  input  logic per_vld_i,
  output logic lock_o,
  output logic long_o,
  output logic first_o
);

  logic [1:0] hl_q;
  pulse_cls_e prev_q, cls;
  logic       lock_q, long_q;

  assign cls = classify(hl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hl_q   <= 2'd0;
      prev_q <= CLS_NONE;
      lock_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      if (!hv_i) hl_q <= 2'd0;
      else if (rise_i && hl_q != 2'd3) hl_q <= hl_q + 2'd1;
      if (hv_fall_i) begin
        prev_q <= cls;
        lock_q <= per_vld_i && cls != CLS_NONE && prev_q != CLS_NONE && cls != prev_q;
        long_q <= (cls == CLS_ONE);
      end
    end
  end

  assign lock_o  = lock_q;
  assign long_o  = long_q;
  assign first_o = hv_i && rise_i && hl_q == 2'd0;

endmodule

// File: rtl/csync_broad.sv
module csync_broad #(
  parameter int CNT_W   = 12,
  parameter int VS_HALF = 5,
  localparam int SEG_W  = $clog2(VS_HALF + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             long_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             run_o,
  output logic             gap_o,
  output logic             broad_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [SEG_W-1:0] seg_o,
  output logic [CNT_W-1:0] half_o
);

  localparam logic [SEG_W-1:0] SEG_LONG  = SEG_W'(VS_HALF - 1);
  localparam logic [SEG_W-1:0] SEG_SHORT = SEG_W'(VS_HALF);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic             run_q, short_q;
  logic [CNT_W-1:0] pos_q, half_q, wid_q;
  logic [SEG_W-1:0] seg_q, seg_end;

  assign seg_end = short_q ? SEG_SHORT : SEG_LONG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      short_q <= 1'b0;
      pos_q   <= '0;
      seg_q   <= '0;
      half_q  <= '0;
      wid_q   <= '0;
    end else if (start_i) begin
      // leading edge cycle itself is position 0
      run_q   <= 1'b1;
      short_q <= ~long_i;
      pos_q   <= CNT_ONE;
      seg_q   <= '0;
      half_q  <= half_i;
      wid_q   <= wid_i;
    end else if (run_q) begin
      if (pos_q == half_q - CNT_ONE) begin
        pos_q <= '0;
        if (seg_q == seg_end) run_q <= 1'b0;
        else seg_q <= seg_q + SEG_W'(1);
      end else begin
        pos_q <= pos_q + CNT_ONE;
      end
    end
  end

  assign run_o   = run_q;
  assign gap_o   = short_q && seg_q == '0;
  assign broad_o = ({1'b0, pos_q} + {1'b0, wid_q}) < {1'b0, half_q};
  assign pos_o   = pos_q;
  assign seg_o   = seg_q;
  assign half_o  = half_q;

endmodule

// File: rtl/csync_synth.sv
module csync_synth #(
  parameter bit SYNC_ACTIVE_LOW = 1'b1,
  parameter bit HELP_ACTIVE_LOW = 1'b0,
  parameter int CNT_W           = 12,
  parameter int VS_HALF         = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vhelp_i,
  output logic csync_o
);

  localparam int SEG_W = $clog2(VS_HALF + 1) + 1;
  localparam logic [CNT_W-1:0] HALF_MIN = CNT_W'(2);

  logic             hs_s, rise_s, fall_s, hv_s, hv_fall_s;
  logic [CNT_W-1:0] meas_half_s, meas_wid_s;
  logic             per_vld_s, lock_s, long_s, first_s, start_s;
  logic             run_s, gap_s, broad_s;
  logic [CNT_W-1:0] pos_s, half_s;
  logic [SEG_W-1:0] seg_s;
  logic             act_s, csync_q;

  csync_in_stage #(
    .SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW),
    .HELP_ACTIVE_LOW(HELP_ACTIVE_LOW)
  ) u_in (
    .clk_i, .rst_ni, .hsync_i, .vhelp_i,
    .hs_o(hs_s), .hs_rise_o(rise_s), .hs_fall_o(fall_s),
    .hv_o(hv_s), .hv_fall_o(hv_fall_s)
  );

  csync_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni,
    .rise_i(rise_s), .fall_i(fall_s),
    .half_o(meas_half_s), .wid_o(meas_wid_s), .vld_o(per_vld_s)
  );

  csync_field u_field (
    .clk_i, .rst_ni,
    .rise_i(rise_s), .hv_i(hv_s), .hv_fall_i(hv_fall_s), .per_vld_i(per_vld_s),
    .lock_o(lock_s), .long_o(long_s), .first_o(first_s)
  );

  assign start_s = first_s && lock_s && meas_half_s >= HALF_MIN;

  csync_broad #(.CNT_W(CNT_W), .VS_HALF(VS_HALF)) u_broad (
    .clk_i, .rst_ni,
    .start_i(start_s), .long_i(long_s), .half_i(meas_half_s), .wid_i(meas_wid_s),
    .run_o(run_s), .gap_o(gap_s), .broad_o(broad_s),
    .pos_o(pos_s), .seg_o(seg_s), .half_o(half_s)
  );

  assign act_s = (run_s && !gap_s) ? broad_s : hs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csync_q <= SYNC_ACTIVE_LOW;
    else         csync_q <= act_s ^ SYNC_ACTIVE_LOW;
  end

  assign csync_o = csync_q;

endmodule

// File: rtl/csync_synth_chk.sv
module csync_synth_chk #(
  parameter bit SYNC_ACTIVE_LOW = 1'b1,
  parameter int CNT_W           = 12,
  parameter int VS_HALF         = 5,
  localparam int SEG_W          = $clog2(VS_HALF + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csync_o,
  input logic             hs_s,
  input logic             run_s,
  input logic             lock_s,
  input logic             hv_fall_s,
  input logic [CNT_W-1:0] pos_s,
  input logic [SEG_W-1:0] seg_s,
  input logic [CNT_W-1:0] half_s
);

  // R2
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_s |=> csync_o == ($past(hs_s) ^ SYNC_ACTIVE_LOW));

  // R5
  run_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_s) |-> $past(lock_s));

  // R4
  lock_at_pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_s) |-> $past(hv_fall_s));

  // R7
  seg_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_s |-> seg_s <= SEG_W'(VS_HALF));

  // R6
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_s |-> pos_s < half_s);

endmodule

bind csync_synth csync_synth_chk #(
  .SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW),
  .CNT_W(CNT_W),
  .VS_HALF(VS_HALF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csync_o(csync_o), .hs_s(hs_s),
  .run_s(run_s), .lock_s(lock_s), .hv_fall_s(hv_fall_s),
  .pos_s(pos_s), .seg_s(seg_s), .half_s(half_s)
);

// File: tb/csync_synth_bench.sv
`timescale 1ns/1ps
module csync_synth_bench;

  localparam int LINE = 64;
  localparam int SW   = 5;
  localparam int NH   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 1'b1;
  logic vhelp_i = 1'b0;
  logic csync_o;

  int compared = 0, mismatched = 0;
  string phase = "R2";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csync_synth u_csync_synth (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync_i), .vhelp_i(vhelp_i), .csync_o(csync_o)
  );

  // reference model state
  int cyc = 0, last_rise = -1, period = 0, width = 0, hl = 0, prev_cls = 0, cls = 0;
  bit per_vld = 0, lock = 0, exp_long = 0, prev_a = 0, prev_v = 0, act_prev = 0, exp_out = 1;
  int run_t = -1, run_h = 0, run_w = 0, run_s0 = 0;
  string tag = "R2";
  int probe_at = -1, gap_at = -1, win_lo = -1, win_hi = -1, win_cnt = 0;
  bit probe_exp = 0;
  string probe_tag = "R2";

  always @(posedge clk) begin
    if (rst_n) begin
      bit a, v, rise, fall, vfall, start, act;
      int vt;
      cyc++;
      a = ~hsync_i;
      v = vhelp_i;
      rise = a & ~prev_a;
      fall = ~a & prev_a;
      vfall = ~v & prev_v;
      start = rise && v && hl == 0 && lock && (period / 2) >= 2;
      if (start) begin
        run_t = cyc; run_h = period / 2; run_w = width; run_s0 = exp_long ? 0 : 1;
        probe_at = cyc + run_s0 * run_h + run_w + 1; probe_exp = 1; probe_tag = phase;
        win_lo = cyc + run_s0 * run_h + 1; win_hi = win_lo + NH * run_h - 1; win_cnt = 0;
        gap_at = run_s0 ? cyc + run_w + 1 : -1;
      end else if (rise && v && hl == 0) begin
        probe_at = cyc + width + 1; probe_exp = 0; probe_tag = phase;
      end
      vt = cyc - run_t;
      tag = phase;
      if (run_t >= 0 && vt >= 1 && vt <= (run_s0 + NH) * run_h - 1) begin
        if (vt >= run_s0 * run_h) begin
          act = ((vt - run_s0 * run_h) % run_h) < (run_h - run_w);
          tag = "R6";
        end else begin
          act = a;
          tag = "R8";
        end
      end else act = a;
      if (rise) begin
        if (last_rise >= 0) begin period = cyc - last_rise; per_vld = 1; end
        last_rise = cyc;
      end
      if (fall && last_rise >= 0) width = cyc - last_rise;
      if (vfall) begin
        cls = (hl == 1) ? 1 : (hl == 2) ? 2 : 0;
        lock = per_vld && cls != 0 && prev_cls != 0 && cls != prev_cls;
        exp_long = (cls == 1);
        prev_cls = cls;
      end
      if (!v) hl = 0;
      else if (rise && hl < 3) hl++;
      exp_out = ~act_prev;
      act_prev = act;
      prev_a = a;
      prev_v = v;
    end
  end

  task automatic check(input bit got, input bit exp, input string req, input string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, got, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(csync_o, exp_out, tag, "csync_o");
      if (cyc >= win_lo && cyc <= win_hi) win_cnt += !csync_o;
      if (cyc == win_hi) begin
        compared++;
        if (win_cnt != NH * (LINE / 2 - SW)) begin
          mismatched++;
          $display("FAIL R3/R7 broad active cycles: actual %0d expected %0d", win_cnt, NH * (LINE / 2 - SW));
        end
      end
      if (cyc == probe_at) check(!csync_o, probe_exp, probe_tag, "broad probe (R5)");
      if (cyc == gap_at) check(!csync_o, 1'b0, "R8", "short-field gap");
    end
  end

  task automatic drive_line(input bit hv_a, input bit hv_b, input bit mid_pulse);
    for (int p = 0; p < LINE; p++) begin
      @(negedge clk);
      hsync_i = ~(p < SW);
      if (mid_pulse) vhelp_i = (p >= 10 && p < 30);
      else vhelp_i = (p < 40) ? hv_a : hv_b;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_line(1'b0, 1'b0, 1'b0);
  endtask

  task automatic pulse(input int lines);
    drive_line(1'b0, 1'b1, 1'b0);
    for (int i = 1; i < lines; i++) drive_line(1'b1, 1'b1, 1'b0);
    drive_line(1'b1, 1'b0, 1'b0);
    idle(7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 R10: inactive level is high with active-low sync
    check(csync_o, 1'b1, "R1", "reset level (R10)");
    rst_n = 1'b1;
    idle(4);
    phase = "R5"; pulse(1);
    phase = "R5"; pulse(2);
    phase = "R8"; pulse(1);
    phase = "R6"; pulse(2);
    phase = "R7"; pulse(1);
    phase = "R4"; pulse(3);
    phase = "R9"; pulse(2);
    phase = "R9"; pulse(1);
    phase = "R4"; drive_line(1'b0, 1'b0, 1'b1); idle(7);
    phase = "R4"; pulse(2);
    phase = "R9"; pulse(1);
    phase = "R9"; pulse(2);
    phase = "R2"; idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule